// File: doc/BRIEF.md
# Nine-Bit Serial Frame Transmitter

This block turns one byte, written into its transmit buffer, into an 11-bit asynchronous serial frame. The frame is a low start bit, eight data bits sent least significant bit first, a ninth bit, and a high stop bit. The ninth bit marks address frames in a multi-drop link, or it carries even parity over the data. It comes from a one-shot software flag (the "ninth-bit flag") or from computed parity, depending on the selected mode and a parity-enable setting.

A separate control write loads the ninth-bit flag, the mode select (mode 2 or mode 3) and the parity enable. The ninth-bit flag is consumed by each frame: it clears when a buffer write is accepted. The line advances one bit per pulse on `baud_tick`, which comes from an external rate generator. The done flag `ti` rises when the ninth bit goes on the line, not at the stop bit. It stays set until `ti_clr` is pulsed.

The sequencer has five states:
- IDLE: the line is high and a buffer write is accepted. On a write it moves to START.
- START: moves to DATA on a tick.
- DATA: shifts out one bit per tick. After the eighth data bit it moves to NINTH and sets `ti`.
- NINTH: moves to STOP on a tick.
- STOP: returns to IDLE on a tick.

Top module: `nbt_top`

## Requirements
- R1: After reset, `tx` is 1 and `busy`, `ti` and `tb8_o` are 0.
- R2: The cycle after a buffer write is accepted, `tx` goes to 0 for the start bit. It then carries data bit 0 through data bit 7, then the ninth bit, then a stop bit of 1, and then returns to idle high. Each bit changes only on the clock edge where `baud_tick` is 1. A tick in the cycle where the write is accepted does not shorten the start bit.
- R3: With parity disabled (`pen_o`-side setting 0), the ninth bit equals the ninth-bit flag as it stood when the buffer write was accepted.
- R4: Accepting a buffer write clears the ninth-bit flag, and `tb8_o` reads 0 from the next cycle. If a control write happens in the same cycle, the clear still wins.
- R5: In mode 3 (`ctl_mode3`=1) with parity enabled, the ninth bit is the XOR of the eight data bits, which makes the count of ones over nine bits even. The flag is ignored.
- R6: In mode 2 (`ctl_mode3`=0), the parity enable has no effect and the ninth bit always comes from the flag.
- R7: `ti` rises on the same edge where the ninth bit first appears on `tx`.
- R8: `ti` stays 1 until a cycle with `ti_clr`=1 clears it on the next edge. Clearing does not disturb a frame in progress. A set and a clear in the same cycle leave `ti` at 1.
- R9: `busy` is 1 from the edge that accepts a write until the edge that ends the stop bit. A buffer write while `busy` is 1 is ignored: the frame and the flag are unchanged.
- R10: A control write during a frame does not change the ninth bit of that frame.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| ctl_wr | input | 1 | Control write strobe |
| ctl_tb8 | input | 1 | Ninth-bit flag value to load |
| ctl_mode3 | input | 1 | 1 selects mode 3, 0 selects mode 2 |
| ctl_pen | input | 1 | Parity enable (effective in mode 3 only) |
| buf_wr | input | 1 | Transmit buffer write strobe |
| buf_data | input | DATA_W | Byte to send |
| baud_tick | input | 1 | One pulse per bit time |
| ti_clr | input | 1 | Clears the done flag |
| tx | output | 1 | Serial line, idles high |
| busy | output | 1 | A frame is in progress |
| ti | output | 1 | Done flag, set at the ninth bit |
| tb8_o | output | 1 | Current ninth-bit flag |

## Verification
The hardest case to reach from the ports is a collision with an active frame. This covers a buffer write and a control write that land while a frame is mid-flight, and a clear that coincides with the edge that sets `ti`. To reach these, the stimulus holds `ti_clr` high through a whole frame, and in another frame injects writes a few ticks after the start. A behavioural reference model, indexed by bit position, checks every cycle that the ninth bit on the line and the flag are unaffected. The tick spacing is varied, including a tick on every cycle, so that a tick coincides with the accepting edge.

// File: rtl/nbt_pkg.sv
package nbt_pkg;
    typedef enum logic [2:0] {
        ST_IDLE,
        ST_START,
        ST_DATA,
        ST_NINTH,
        ST_STOP
    } nbt_state_t;
endpackage

// File: rtl/nbt_ctl_reg.sv
module nbt_ctl_reg (
    input  logic clk,
    input  logic rst_n,
    input  logic ctl_wr,
    input  logic ctl_tb8,
    input  logic ctl_mode3,
    input  logic ctl_pen,
    input  logic accept,
    output logic tb8_q,
    output logic mode3_q,
    output logic pen_q
);
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            tb8_q   <= 1'b0;
            mode3_q <= 1'b0;
            pen_q   <= 1'b0;
        end else begin
            if (accept)
                tb8_q <= 1'b0;
            else if (ctl_wr)
                tb8_q <= ctl_tb8;
            if (ctl_wr) begin
                mode3_q <= ctl_mode3;
                pen_q   <= ctl_pen;
            end
        end
    end
endmodule

// File: rtl/nbt_ninth_sel.sv
module nbt_ninth_sel #(
    parameter int DATA_W = 8
) (
    input  logic [DATA_W-1:0] data,
    input  logic              tb8,
    input  logic              mode3,
    input  logic              pen,
    output logic              ninth
);
    logic even_par;
    assign even_par = ^data;
    assign ninth    = (mode3 && pen) ? even_par : tb8;
endmodule

// File: rtl/nbt_fsm.sv
module nbt_fsm
    import nbt_pkg::*;
#(
    parameter int DATA_W = 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              buf_wr,
    input  logic [DATA_W-1:0] buf_data,
    input  logic              ninth_in,
    input  logic              baud_tick,
    input  logic              ti_clr,
    output logic              tx,
    output logic              busy,
    output logic              ti,
    output logic              accept
);
    localparam int CNT_W = (DATA_W > 1) ? $clog2(DATA_W) : 1;
    localparam logic [CNT_W-1:0] LAST = CNT_W'(DATA_W - 1);

    nbt_state_t        state_q, state_d;
    logic [DATA_W-1:0] shreg_q;
    logic [CNT_W-1:0]  cnt_q;
    logic              ninth_q;
    logic              ti_q;
    logic              last_data;

    assign accept    = (state_q == ST_IDLE) && buf_wr;
    assign last_data = (state_q == ST_DATA) && baud_tick && (cnt_q == LAST);

    always_comb begin
        state_d = state_q;
        unique case (state_q)
            ST_IDLE:  if (buf_wr)    state_d = ST_START;
            ST_START: if (baud_tick) state_d = ST_DATA;
            ST_DATA:  if (last_data) state_d = ST_NINTH;
            ST_NINTH: if (baud_tick) state_d = ST_STOP;
            ST_STOP:  if (baud_tick) state_d = ST_IDLE;
            default:                 state_d = ST_IDLE;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state_q <= ST_IDLE;
        else        state_q <= state_d;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            shreg_q <= '0;
            cnt_q   <= '0;
            ninth_q <= 1'b0;
        end else if (accept) begin
            shreg_q <= buf_data;
            cnt_q   <= '0;
            ninth_q <= ninth_in;
        end else if ((state_q == ST_DATA) && baud_tick) begin
            shreg_q <= shreg_q >> 1;
            cnt_q   <= cnt_q + 1'b1;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)        ti_q <= 1'b0;
        else if (last_data) ti_q <= 1'b1;
        else if (ti_clr)    ti_q <= 1'b0;
    end

    always_comb begin
        tx   = 1'b1;
        busy = 1'b1;
        unique case (state_q)
            ST_IDLE:  busy = 1'b0;
            ST_START: tx = 1'b0;
            ST_DATA:  tx = shreg_q[0];
            ST_NINTH: tx = ninth_q;
            ST_STOP:  tx = 1'b1;
            default:  busy = 1'b0;
        endcase
        ti = ti_q;
    end
endmodule

// File: rtl/nbt_top.sv
module nbt_top #(
    parameter int DATA_W = 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              ctl_wr,
    input  logic              ctl_tb8,
    input  logic              ctl_mode3,
    input  logic              ctl_pen,
    input  logic              buf_wr,
    input  logic [DATA_W-1:0] buf_data,
    input  logic              baud_tick,
    input  logic              ti_clr,
    output logic              tx,
    output logic              busy,
    output logic              ti,
    output logic              tb8_o
);
    logic accept;
    logic mode3_q;
    logic pen_q;
    logic ninth;

    nbt_ctl_reg u_ctl (
        .clk(clk), .rst_n(rst_n), .ctl_wr(ctl_wr), .ctl_tb8(ctl_tb8),
        .ctl_mode3(ctl_mode3), .ctl_pen(ctl_pen), .accept(accept),
        .tb8_q(tb8_o), .mode3_q(mode3_q), .pen_q(pen_q)
    );

    nbt_ninth_sel #(.DATA_W(DATA_W)) u_sel (
        .data(buf_data), .tb8(tb8_o), .mode3(mode3_q), .pen(pen_q),
        .ninth(ninth)
    );

    nbt_fsm #(.DATA_W(DATA_W)) u_fsm (
        .clk(clk), .rst_n(rst_n), .buf_wr(buf_wr), .buf_data(buf_data),
        .ninth_in(ninth), .baud_tick(baud_tick), .ti_clr(ti_clr),
        .tx(tx), .busy(busy), .ti(ti), .accept(accept)
    );
endmodule

// File: rtl/nbt_chk.sv
module nbt_chk (
    input logic clk,
    input logic rst_n,
    input logic buf_wr,
    input logic ctl_wr,
    input logic ti_clr,
    input logic tx,
    input logic busy,
    input logic ti,
    input logic tb8_o
);
    AST_IDLE_HIGH: assert property (@(posedge clk) disable iff (!rst_n)
        !busy |-> tx); // R2
    AST_START_LOW: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(busy) |-> !tx); // R2
    AST_STOP_HIGH: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(busy) |-> $past(tx)); // R2
    AST_FLAG_CLEARED: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(busy) |-> !tb8_o); // R4
    AST_BUSY_WR_IGNORED: assert property (@(posedge clk) disable iff (!rst_n)
        (busy && buf_wr && !ctl_wr) |=> $stable(tb8_o)); // R9
    AST_TI_IN_FRAME: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(ti) |-> busy); // R7
    AST_TI_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
        (ti && !ti_clr) |=> ti); // R8
endmodule

bind nbt_top nbt_chk u_chk (
    .clk(clk), .rst_n(rst_n), .buf_wr(buf_wr), .ctl_wr(ctl_wr),
    .ti_clr(ti_clr), .tx(tx), .busy(busy), .ti(ti), .tb8_o(tb8_o)
);

// File: tb/sim_nbt_top.sv
`timescale 1ns/1ps
module sim_nbt_top;
    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       ctl_wr = 1'b0, ctl_tb8 = 1'b0, ctl_mode3 = 1'b0, ctl_pen = 1'b0;
    logic       buf_wr = 1'b0;
    logic [7:0] buf_data = 8'h00;
    logic       baud_tick = 1'b0;
    logic       ti_clr = 1'b0;
    logic       tx, busy, ti, tb8_o;

    int total = 0;
    int bad = 0;
    int cycles = 0;
    int tick_gap = 3;
    int tick_cnt = 0;

    // reference model state
    int         m_pos = -1;
    logic [10:0] m_bits = '0;
    logic       m_ti = 1'b0, m_tb8 = 1'b0, m_mode3 = 1'b0, m_pen = 1'b0;
    logic       last_ninth = 1'b0;

    always #5 clk = ~clk;

    nbt_top u0 (
        .clk(clk), .rst_n(rst_n), .ctl_wr(ctl_wr), .ctl_tb8(ctl_tb8),
        .ctl_mode3(ctl_mode3), .ctl_pen(ctl_pen), .buf_wr(buf_wr),
        .buf_data(buf_data), .baud_tick(baud_tick), .ti_clr(ti_clr),
        .tx(tx), .busy(busy), .ti(ti), .tb8_o(tb8_o)
    );

    task automatic check(input string req, input logic act, input logic exp);
        total++;
        if (act !== exp) begin
            bad++;
            $display("FAIL %s actual=%0b expected=%0b time=%0t", req, act, exp, $time);
        end
    endtask

    // behavioural model, advanced on each rising edge
    always @(posedge clk) begin
        if (!rst_n) begin
            m_pos = -1; m_ti = 0; m_tb8 = 0; m_mode3 = 0; m_pen = 0;
        end else begin
            logic nb;
            logic accepted;
            accepted = 0;
            if (m_pos < 0) begin
                if (buf_wr) begin
                    nb = (m_mode3 && m_pen) ? ^buf_data : m_tb8;
                    m_bits = {1'b1, nb, buf_data, 1'b0};
                    m_pos = 0;
                    accepted = 1;
                end
                if (ti_clr) m_ti = 0;
            end else if (baud_tick) begin
                m_pos++;
                if (m_pos == 9) m_ti = 1;
                else if (ti_clr) m_ti = 0;
                if (m_pos == 11) m_pos = -1;
            end else if (ti_clr) begin
                m_ti = 0;
            end
            if (accepted) m_tb8 = 0;
            else if (ctl_wr) m_tb8 = ctl_tb8;
            if (ctl_wr) begin m_mode3 = ctl_mode3; m_pen = ctl_pen; end
        end
    end

    // per-cycle comparison away from the active edge
    always @(negedge clk) begin
        if (rst_n) begin
            check("R2 tx", tx, (m_pos < 0) ? 1'b1 : m_bits[m_pos]);
            check("R9 busy", busy, m_pos >= 0);
            check("R7 ti", ti, m_ti);
            check("R4 tb8", tb8_o, m_tb8);
            if (m_pos == 9) last_ninth = tx;
        end
    end

    // baud tick source
    always @(negedge clk) begin
        #1;
        if (tick_gap <= 1) baud_tick = 1'b1;
        else begin
            baud_tick = (tick_cnt == 0);
            tick_cnt = (tick_cnt + 1) % tick_gap;
        end
    end

    always @(posedge clk) begin
        cycles++;
        if (cycles > 100000) begin
            bad++;
            $display("FAIL watchdog actual=running expected=done");
            $display("test done: total=%0d bad=%0d", total, bad);
            $finish;
        end
    end

    task automatic step(); @(negedge clk); #2; endtask

    task automatic ctl(input logic t8, input logic m3, input logic pe);
        step();
        ctl_wr = 1; ctl_tb8 = t8; ctl_mode3 = m3; ctl_pen = pe;
        step();
        ctl_wr = 0;
    endtask

    task automatic start_frame(input logic [7:0] d);
        step();
        while (busy) step();
        buf_wr = 1; buf_data = d;
        step();
        buf_wr = 0;
    endtask

    task automatic wait_idle();
        while (busy) step();
        step();
    endtask

    task automatic frame(input string req, input logic [7:0] d, input logic exp9);
        start_frame(d);
        wait_idle();
        check(req, last_ninth, exp9);
        check("R4 flag consumed", tb8_o, 1'b0);
        ti_clr = 1; step(); ti_clr = 0; step();
        check("R8 ti cleared", ti, 1'b0);
    endtask

    initial begin
        repeat (3) @(negedge clk);
        check("R1 tx", tx, 1'b1);
        check("R1 busy", busy, 1'b0);
        check("R1 ti", ti, 1'b0);
        check("R1 tb8", tb8_o, 1'b0);
        rst_n = 1;
        // mode 2, flag set
        ctl(1, 0, 0); frame("R3 R6 flag one", 8'hA5, 1'b1);
        // flag not reloaded: ninth falls to 0
        frame("R4 flag reused", 8'h3C, 1'b0);
        // mode 2 with pen: pen ignored
        ctl(1, 0, 1); frame("R6 pen ignored", 8'h03, 1'b1);
        // tick every cycle, mode 3 without parity
        tick_gap = 1;
        ctl(0, 1, 0); frame("R3 mode3 flag zero", 8'hFF, 1'b0);
        tick_gap = 3;
        // mode 3 parity
        ctl(1, 1, 1); frame("R5 parity even data", 8'h03, 1'b0);
        ctl(0, 1, 1);
        ti_clr = 1;   // held across the frame: set wins at ninth-bit edge
        start_frame(8'h07);
        while (m_pos != 9) step();
        check("R8 set wins over clear", ti, 1'b1);
        step(); step();
        check("R8 clear mid-frame", ti, 1'b0);
        check("R8 frame continues", busy, 1'b1);
        ti_clr = 0;
        wait_idle();
        check("R5 parity odd data", last_ninth, 1'b1);
        // collisions during a frame
        tick_gap = 4;
        ctl(1, 1, 0);
        start_frame(8'h80);
        repeat (9) step();
        buf_wr = 1; buf_data = 8'h55; step(); buf_wr = 0;
        check("R9 flag after ignored write", tb8_o, 1'b0);
        ctl(1, 1, 1);
        check("R10 flag loaded mid-frame", tb8_o, 1'b1);
        wait_idle();
        check("R10 ninth kept", last_ninth, 1'b1);
        check("R9 idle after frame", busy, 1'b0);
        check("R9 flag kept", tb8_o, 1'b1);
        // pending flag used with parity disabled
        ctl(1, 1, 0); frame("R3 flag reload", 8'h00, 1'b1);
        repeat (4) step();
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end
endmodule